// File: doc/BRIEF.md
# DSP Data-Memory Address Decoder with Peripheral Register File

This block sits between a DSP core's 16-bit, word-addressed data-memory port and everything the core can reach through it. Each access goes to one of three places. The first is a data RAM at the bottom of the address space. The second is a read-only data ROM window. The third is a page of memory-mapped control registers at the top of the space. Any other address is unmapped and answers reads with all ones.

The register page holds several groups of state:
- the setup for a block-transfer (DMA) engine;
- the outgoing mailbox halves that the DSP posts to the host CPU;
- an interrupt doorbell towards the CPU;
- the address, format and history registers of a sample-decoding accelerator;
- sixteen decoder coefficients.

Some register writes are masked to the widths the engines accept. One write is a command: writing the transfer length launches the transfer on the same edge that stores it.

The RAM and ROM arrays are external synchronous memories. The transfer engine, the accelerator and the CPU-side mailbox sit outside the block and connect through plain ports. Storage is big-endian, so every word crosses the memory ports with its two bytes exchanged.

Top module: `dsp_dmem_decoder`

## Requirements
- R1: With default parameters, word addresses 0x0000–0x03FF reach the data RAM and 0x0800–0x0BFF reach the ROM, at ROM offset = address − 0x0800. Addresses 0xFF00–0xFFFF reach the register page at offset = address − 0xFF00. `ram_we` is asserted only for a RAM write, and `rom_en` only for a ROM read.
- R2: A read of any other address, for example 0x0400–0x07FF or 0x0C00–0xFEFF, returns 0xFFFF.
- R3: A write to the ROM window or to an unmapped address changes nothing and raises `illegal_pulse`.
- R4: A bus word W is stored as {W[7:0],W[15:8]} on `ram_wdata`, and memory data M is returned as {M[7:0],M[15:8]}.
- R5: Offset 0x00 (host-address high) keeps wdata[9:0] and reads back zero-extended. Offset 0x01 (host-address low) stores wdata with bits 1:0 cleared. `dma_xmem_addr` is {high[9:0], low}.
- R6: Offset 0x02 (local transfer address) stores wdata with bit 0 cleared. Offset 0x03 (transfer control) keeps only bits 1:0.
- R7: Offset 0x04 (length) stores wdata with bits 1:0 cleared and pulses `dma_start` in the cycle the new length appears. In that cycle the outputs already show every transfer register.
- R8: Offsets 0x08/0x09 read the CPU-to-DSP mailbox inputs (high/low), and a DSP write to either is illegal and raises `illegal_pulse`. Offsets 0x0A/0x0B are the DSP-to-CPU mailbox high/low, both readable and writable.
- R9: A write to offset 0x0C with bit 0 set pulses `cpu_irq_pulse`, and with bit 0 clear does nothing. A read of 0x0C returns 1 when `cpu_irq_pending` is high and 0 otherwise.
- R10: The accelerator registers sit at offsets 0x10–0x1A: begin hi/lo, end hi/lo, current hi/lo, format, predictor, history-1, history-2, gain. Coefficient k (0–15) is written at offset 0x20+k and appears on `coef_flat[16k+:16]`. Coefficient offsets, offsets 0x30/0x31 and every other unlisted offset read 0, and writes to 0x30/0x31 or other unlisted offsets are ignored without an illegal flag.
- R11: Reset clears the DSP-to-CPU mailbox, all transfer registers, all accelerator registers and coefficients, and all pulses.
- R12: Read data is presented with `rd_valid` exactly one cycle after a read request. `dma_start`, `cpu_irq_pulse` and `illegal_pulse` each last one cycle per causing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after a read) |
| rd_data | output | 16 | Read data |
| ram_en | output | 1 | Data RAM enable |
| ram_we | output | 1 | Data RAM write enable |
| ram_addr | output | RAM_AW | Data RAM word address |
| ram_wdata | output | 16 | Byte-swapped RAM write data |
| ram_rdata | input | 16 | RAM read data, one cycle after enable |
| rom_en | output | 1 | Data ROM read enable |
| rom_addr | output | ROM_AW | ROM word offset |
| rom_rdata | input | 16 | ROM read data, one cycle after enable |
| cpu_mbox_hi | input | 16 | CPU-to-DSP mailbox, high half |
| cpu_mbox_lo | input | 16 | CPU-to-DSP mailbox, low half |
| cpu_irq_pending | input | 1 | DSP-to-CPU interrupt not yet taken |
| dsp_mbox_hi | output | 16 | DSP-to-CPU mailbox, high half |
| dsp_mbox_lo | output | 16 | DSP-to-CPU mailbox, low half |
| cpu_irq_pulse | output | 1 | One-cycle interrupt request to CPU |
| dma_start | output | 1 | One-cycle transfer launch |
| dma_xmem_addr | output | XMEM_HI_W+16 | Host memory address |
| dma_loc_addr | output | 16 | Local data-memory address |
| dma_ctrl | output | 2 | Transfer control bits |
| dma_len | output | 16 | Transfer length |
| acc_begin | output | 32 | Accelerator begin address |
| acc_end | output | 32 | Accelerator end address |
| acc_cur | output | 32 | Accelerator current address |
| acc_fmt | output | 16 | Accelerator format |
| acc_pred | output | 16 | Predictor/scale |
| acc_hist1 | output | 16 | History sample 1 |
| acc_hist2 | output | 16 | History sample 2 |
| acc_gain | output | 16 | Gain |
| coef_flat | output | NUM_COEF*16 | Coefficient bank |
| illegal_pulse | output | 1 | One-cycle illegal-write flag |

## Verification
The assertions assume that the external RAM and ROM return data exactly one cycle after their enable. They also assume that the request inputs hold steady for the whole cycle in which they are sampled. The stimulus meets both conditions: the bench drives requests only on the falling edge, and its memory models answer on the next rising edge. The checks also rely on RAM being read only after it has been written. The random phase keeps to this by reading only RAM locations filled in an earlier directed pass, which lie at both ends of the RAM range.

// File: rtl/dmem_pkg.sv
`timescale 1ns/1ps
package dmem_pkg;
  localparam int DATA_W    = 16;
  localparam int REG_OFS_W = 8;

  typedef enum logic [1:0] {
    TGT_RAM  = 2'd0,
    TGT_ROM  = 2'd1,
    TGT_REG  = 2'd2,
    TGT_NONE = 2'd3
  } tgt_e;

  // register page offsets
  localparam logic [REG_OFS_W-1:0] OFS_XMEM_HI   = 8'h00;
  localparam logic [REG_OFS_W-1:0] OFS_XMEM_LO   = 8'h01;
  localparam logic [REG_OFS_W-1:0] OFS_LOC_ADDR  = 8'h02;
  localparam logic [REG_OFS_W-1:0] OFS_XFER_CTL  = 8'h03;
  localparam logic [REG_OFS_W-1:0] OFS_XFER_LEN  = 8'h04;
  localparam logic [REG_OFS_W-1:0] OFS_INBOX_HI  = 8'h08;
  localparam logic [REG_OFS_W-1:0] OFS_INBOX_LO  = 8'h09;
  localparam logic [REG_OFS_W-1:0] OFS_OUTBOX_HI = 8'h0A;
  localparam logic [REG_OFS_W-1:0] OFS_OUTBOX_LO = 8'h0B;
  localparam logic [REG_OFS_W-1:0] OFS_DOORBELL  = 8'h0C;
  localparam logic [REG_OFS_W-1:0] OFS_ACC_BASE  = 8'h10;
  localparam int                   ACC_REGS      = 11;
  localparam logic [REG_OFS_W-1:0] OFS_COEF_BASE = 8'h20;
  // 0x30 and 0x31 are reserved placeholders: writes accepted, no effect

  function automatic logic [DATA_W-1:0] swap_bytes(input logic [DATA_W-1:0] w);
    return {w[7:0], w[15:8]};
  endfunction
endpackage

// File: rtl/dmem_addr_decode.sv
`timescale 1ns/1ps
module dmem_addr_decode
  import dmem_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int RAM_WORDS   = 1024,
  parameter int ROM_BASE    = 'h0800,
  parameter int ROM_WORDS   = 1024,
  parameter int PERIPH_BASE = 'hFF00,
  localparam int ROM_AW     = $clog2(ROM_WORDS)
) (
  input  logic [ADDR_W-1:0]    addr,
  output tgt_e                 tgt,
  output logic [REG_OFS_W-1:0] reg_ofs,
  output logic [ROM_AW-1:0]    rom_ofs
);
  localparam logic [ADDR_W:0]   RAM_TOP = (ADDR_W+1)'(RAM_WORDS);
  localparam logic [ADDR_W:0]   ROM_LO  = (ADDR_W+1)'(ROM_BASE);
  localparam logic [ADDR_W:0]   ROM_HI  = (ADDR_W+1)'(ROM_BASE + ROM_WORDS);
  localparam logic [ADDR_W:0]   REG_LO  = (ADDR_W+1)'(PERIPH_BASE);
  localparam logic [ADDR_W-1:0] PB      = ADDR_W'(PERIPH_BASE);
  localparam logic [ADDR_W-1:0] RB      = ADDR_W'(ROM_BASE);

  logic [ADDR_W:0] a_ext;
  assign a_ext = {1'b0, addr};

  // register page has priority, then RAM, then the ROM window
  always_comb begin
    if (a_ext >= REG_LO)                          tgt = TGT_REG;
    else if (a_ext < RAM_TOP)                     tgt = TGT_RAM;
    else if ((a_ext >= ROM_LO) && (a_ext < ROM_HI)) tgt = TGT_ROM;
    else                                          tgt = TGT_NONE;
  end

  assign reg_ofs = addr[REG_OFS_W-1:0] - PB[REG_OFS_W-1:0];
  assign rom_ofs = addr[ROM_AW-1:0] - RB[ROM_AW-1:0];
endmodule

// File: rtl/dmem_xfer_regs.sv
`timescale 1ns/1ps
module dmem_xfer_regs
  import dmem_pkg::*;
#(
  parameter int XMEM_HI_W = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [REG_OFS_W-1:0]      ofs,
  input  logic [DATA_W-1:0]         wdata,
  output logic [XMEM_HI_W+DATA_W-1:0] xmem_addr,
  output logic [DATA_W-1:0]         loc_addr,
  output logic [1:0]                ctrl,
  output logic [DATA_W-1:0]         len,
  output logic                      start,
  output logic [DATA_W-1:0]         rd_data
);
  logic [XMEM_HI_W-1:0] hi_q, hi_d;
  logic [DATA_W-1:0]    lo_q, lo_d, loc_q, loc_d, len_q, len_d;
  logic [1:0]           ctl_q, ctl_d;
  logic                 start_q, start_d;

  always_comb begin
    hi_d    = hi_q;
    lo_d    = lo_q;
    loc_d   = loc_q;
    ctl_d   = ctl_q;
    len_d   = len_q;
    start_d = 1'b0;
    if (wr_en) begin
      unique case (ofs)
        OFS_XMEM_HI:  hi_d  = wdata[XMEM_HI_W-1:0];
        OFS_XMEM_LO:  lo_d  = {wdata[DATA_W-1:2], 2'b00};
        OFS_LOC_ADDR: loc_d = {wdata[DATA_W-1:1], 1'b0};
        OFS_XFER_CTL: ctl_d = wdata[1:0];
        OFS_XFER_LEN: begin
          len_d   = {wdata[DATA_W-1:2], 2'b00};
          start_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      lo_q    <= '0;
      loc_q   <= '0;
      ctl_q   <= '0;
      len_q   <= '0;
      start_q <= 1'b0;
    end else begin
      hi_q    <= hi_d;
      lo_q    <= lo_d;
      loc_q   <= loc_d;
      ctl_q   <= ctl_d;
      len_q   <= len_d;
      start_q <= start_d;
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (ofs)
      OFS_XMEM_HI:  rd_data = DATA_W'(hi_q);
      OFS_XMEM_LO:  rd_data = lo_q;
      OFS_LOC_ADDR: rd_data = loc_q;
      OFS_XFER_CTL: rd_data = DATA_W'(ctl_q);
      OFS_XFER_LEN: rd_data = len_q;
      default: ;
    endcase
  end

  assign xmem_addr = {hi_q, lo_q};
  assign loc_addr  = loc_q;
  assign ctrl      = ctl_q;
  assign len       = len_q;
  assign start     = start_q;
endmodule

// File: rtl/dmem_mbox_irq.sv
`timescale 1ns/1ps
module dmem_mbox_irq
  import dmem_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_OFS_W-1:0] ofs,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [DATA_W-1:0]    in_hi,
  input  logic [DATA_W-1:0]    in_lo,
  input  logic                 irq_pending,
  output logic [DATA_W-1:0]    out_hi,
  output logic [DATA_W-1:0]    out_lo,
  output logic                 irq_pulse,
  output logic                 bad_write,
  output logic [DATA_W-1:0]    rd_data
);
  logic [DATA_W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic              irq_q, irq_d;

  always_comb begin
    hi_d      = hi_q;
    lo_d      = lo_q;
    irq_d     = 1'b0;
    bad_write = 1'b0;
    if (wr_en) begin
      unique case (ofs)
        OFS_OUTBOX_HI: hi_d = wdata;
        OFS_OUTBOX_LO: lo_d = wdata;
        OFS_DOORBELL:  irq_d = wdata[0];
        OFS_INBOX_HI,
        OFS_INBOX_LO:  bad_write = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      hi_q  <= hi_d;
      lo_q  <= lo_d;
      irq_q <= irq_d;
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (ofs)
      OFS_INBOX_HI:  rd_data = in_hi;
      OFS_INBOX_LO:  rd_data = in_lo;
      OFS_OUTBOX_HI: rd_data = hi_q;
      OFS_OUTBOX_LO: rd_data = lo_q;
      OFS_DOORBELL:  rd_data = DATA_W'(irq_pending);
      default: ;
    endcase
  end

  assign out_hi    = hi_q;
  assign out_lo    = lo_q;
  assign irq_pulse = irq_q;
endmodule

// File: rtl/dmem_accel_regs.sv
`timescale 1ns/1ps
module dmem_accel_regs
  import dmem_pkg::*;
#(
  parameter int NUM_COEF = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [REG_OFS_W-1:0]       ofs,
  input  logic [DATA_W-1:0]          wdata,
  output logic [2*DATA_W-1:0]        acc_begin,
  output logic [2*DATA_W-1:0]        acc_end,
  output logic [2*DATA_W-1:0]        acc_cur,
  output logic [DATA_W-1:0]          acc_fmt,
  output logic [DATA_W-1:0]          acc_pred,
  output logic [DATA_W-1:0]          acc_hist1,
  output logic [DATA_W-1:0]          acc_hist2,
  output logic [DATA_W-1:0]          acc_gain,
  output logic [NUM_COEF*DATA_W-1:0] coef_flat,
  output logic [DATA_W-1:0]          rd_data
);
  logic [DATA_W-1:0]   acc_q  [ACC_REGS];
  logic [DATA_W-1:0]   acc_d  [ACC_REGS];
  logic [DATA_W-1:0]   coef_q [NUM_COEF];
  logic [DATA_W-1:0]   coef_d [NUM_COEF];
  logic [ACC_REGS-1:0] acc_hit;
  logic [NUM_COEF-1:0] coef_hit;

  // one write strobe per register, each decoded at its own offset
  for (genvar i = 0; i < ACC_REGS; i++) begin : g_acc_hit
    assign acc_hit[i] = wr_en && (ofs == OFS_ACC_BASE + REG_OFS_W'(i));
  end
  for (genvar k = 0; k < NUM_COEF; k++) begin : g_coef_hit
    assign coef_hit[k] = wr_en && (ofs == OFS_COEF_BASE + REG_OFS_W'(k));
    assign coef_flat[k*DATA_W +: DATA_W] = coef_q[k];
  end

  always_comb begin
    for (int i = 0; i < ACC_REGS; i++) acc_d[i] = acc_hit[i] ? wdata : acc_q[i];
    for (int k = 0; k < NUM_COEF; k++) coef_d[k] = coef_hit[k] ? wdata : coef_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ACC_REGS; i++) acc_q[i] <= '0;
      for (int k = 0; k < NUM_COEF; k++) coef_q[k] <= '0;
    end else begin
      for (int i = 0; i < ACC_REGS; i++) acc_q[i] <= acc_d[i];
      for (int k = 0; k < NUM_COEF; k++) coef_q[k] <= coef_d[k];
    end
  end

  // coefficients are write-only from the bus; only the accelerator state reads back
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < ACC_REGS; i++) begin
      if (ofs == OFS_ACC_BASE + REG_OFS_W'(i)) rd_data = acc_q[i];
    end
  end

  assign acc_begin = {acc_q[0], acc_q[1]};
  assign acc_end   = {acc_q[2], acc_q[3]};
  assign acc_cur   = {acc_q[4], acc_q[5]};
  assign acc_fmt   = acc_q[6];
  assign acc_pred  = acc_q[7];
  assign acc_hist1 = acc_q[8];
  assign acc_hist2 = acc_q[9];
  assign acc_gain  = acc_q[10];
endmodule

// File: rtl/dsp_dmem_decoder.sv
`timescale 1ns/1ps
module dsp_dmem_decoder
  import dmem_pkg::*;
#(
  parameter int RAM_WORDS   = 1024,
  parameter int ROM_BASE    = 'h0800,
  parameter int ROM_WORDS   = 1024,
  parameter int PERIPH_BASE = 'hFF00,
  parameter int XMEM_HI_W   = 10,
  parameter int NUM_COEF    = 16,
  localparam int ADDR_W     = 16,
  localparam int RAM_AW     = $clog2(RAM_WORDS),
  localparam int ROM_AW     = $clog2(ROM_WORDS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_we,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  output logic                       rd_valid,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       ram_en,
  output logic                       ram_we,
  output logic [RAM_AW-1:0]          ram_addr,
  output logic [DATA_W-1:0]          ram_wdata,
  input  logic [DATA_W-1:0]          ram_rdata,
  output logic                       rom_en,
  output logic [ROM_AW-1:0]          rom_addr,
  input  logic [DATA_W-1:0]          rom_rdata,
  input  logic [DATA_W-1:0]          cpu_mbox_hi,
  input  logic [DATA_W-1:0]          cpu_mbox_lo,
  input  logic                       cpu_irq_pending,
  output logic [DATA_W-1:0]          dsp_mbox_hi,
  output logic [DATA_W-1:0]          dsp_mbox_lo,
  output logic                       cpu_irq_pulse,
  output logic                       dma_start,
  output logic [XMEM_HI_W+DATA_W-1:0] dma_xmem_addr,
  output logic [DATA_W-1:0]          dma_loc_addr,
  output logic [1:0]                 dma_ctrl,
  output logic [DATA_W-1:0]          dma_len,
  output logic [2*DATA_W-1:0]        acc_begin,
  output logic [2*DATA_W-1:0]        acc_end,
  output logic [2*DATA_W-1:0]        acc_cur,
  output logic [DATA_W-1:0]          acc_fmt,
  output logic [DATA_W-1:0]          acc_pred,
  output logic [DATA_W-1:0]          acc_hist1,
  output logic [DATA_W-1:0]          acc_hist2,
  output logic [DATA_W-1:0]          acc_gain,
  output logic [NUM_COEF*DATA_W-1:0] coef_flat,
  output logic                       illegal_pulse
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  tgt_e                 tgt;
  logic [REG_OFS_W-1:0] reg_ofs;
  logic [ROM_AW-1:0]    rom_ofs;

  dmem_addr_decode #(
    .ADDR_W(ADDR_W), .RAM_WORDS(RAM_WORDS), .ROM_BASE(ROM_BASE),
    .ROM_WORDS(ROM_WORDS), .PERIPH_BASE(PERIPH_BASE)
  ) u_dec (
    .addr(req_addr), .tgt(tgt), .reg_ofs(reg_ofs), .rom_ofs(rom_ofs)
  );

  logic reg_wr, rd_req, mbox_bad;
  logic [DATA_W-1:0] xfer_rd, mbox_rd, acc_rd, reg_rd;

  assign rd_req = req_valid && !req_we;
  assign reg_wr = req_valid && req_we && (tgt == TGT_REG);

  // memory-side strobes
  assign ram_en    = req_valid && (tgt == TGT_RAM);
  assign ram_we    = ram_en && req_we;
  assign ram_addr  = req_addr[RAM_AW-1:0];
  assign ram_wdata = swap_bytes(req_wdata);
  assign rom_en    = rd_req && (tgt == TGT_ROM);
  assign rom_addr  = rom_ofs;

  dmem_xfer_regs #(.XMEM_HI_W(XMEM_HI_W)) u_xfer (
    .clk(clk), .rst_n(rst_ni), .wr_en(reg_wr), .ofs(reg_ofs), .wdata(req_wdata),
    .xmem_addr(dma_xmem_addr), .loc_addr(dma_loc_addr), .ctrl(dma_ctrl),
    .len(dma_len), .start(dma_start), .rd_data(xfer_rd)
  );

  dmem_mbox_irq u_mbox (
    .clk(clk), .rst_n(rst_ni), .wr_en(reg_wr), .ofs(reg_ofs), .wdata(req_wdata),
    .in_hi(cpu_mbox_hi), .in_lo(cpu_mbox_lo), .irq_pending(cpu_irq_pending),
    .out_hi(dsp_mbox_hi), .out_lo(dsp_mbox_lo), .irq_pulse(cpu_irq_pulse),
    .bad_write(mbox_bad), .rd_data(mbox_rd)
  );

  dmem_accel_regs #(.NUM_COEF(NUM_COEF)) u_acc (
    .clk(clk), .rst_n(rst_ni), .wr_en(reg_wr), .ofs(reg_ofs), .wdata(req_wdata),
    .acc_begin(acc_begin), .acc_end(acc_end), .acc_cur(acc_cur),
    .acc_fmt(acc_fmt), .acc_pred(acc_pred), .acc_hist1(acc_hist1),
    .acc_hist2(acc_hist2), .acc_gain(acc_gain), .coef_flat(coef_flat),
    .rd_data(acc_rd)
  );

  // unknown offsets return zero from every group, so OR is the merge
  assign reg_rd = xfer_rd | mbox_rd | acc_rd;

  logic              illegal_d;
  logic              rd_valid_q, illegal_q;
  tgt_e              src_q, src_d;
  logic [DATA_W-1:0] reg_rd_q, reg_rd_d;

  always_comb begin
    illegal_d = req_valid && req_we &&
                ((tgt == TGT_ROM) || (tgt == TGT_NONE) || ((tgt == TGT_REG) && mbox_bad));
    src_d     = rd_req ? tgt : src_q;
    reg_rd_d  = (rd_req && (tgt == TGT_REG)) ? reg_rd : reg_rd_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      illegal_q  <= 1'b0;
      src_q      <= TGT_NONE;
      reg_rd_q   <= '0;
    end else begin
      rd_valid_q <= rd_req;
      illegal_q  <= illegal_d;
      src_q      <= src_d;
      reg_rd_q   <= reg_rd_d;
    end
  end

  always_comb begin
    unique case (src_q)
      TGT_RAM: rd_data = swap_bytes(ram_rdata);
      TGT_ROM: rd_data = swap_bytes(rom_rdata);
      TGT_REG: rd_data = reg_rd_q;
      default: rd_data = '1;
    endcase
  end

  assign rd_valid      = rd_valid_q;
  assign illegal_pulse = illegal_q;
endmodule

// File: rtl/dsp_dmem_decoder_chk.sv
`timescale 1ns/1ps
module dsp_dmem_decoder_chk #(
  parameter int RAM_WORDS   = 1024,
  parameter int ROM_BASE    = 'h0800,
  parameter int ROM_WORDS   = 1024,
  parameter int PERIPH_BASE = 'hFF00,
  parameter int XMEM_HI_W   = 10
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_we,
  input logic [15:0] req_addr,
  input logic [15:0] req_wdata,
  input logic        rd_valid,
  input logic [15:0] rd_data,
  input logic        ram_we,
  input logic        rom_en,
  input logic        cpu_irq_pulse,
  input logic        dma_start,
  input logic [15:0] dma_len,
  input logic        illegal_pulse
);
  logic        in_ram, in_rom, in_reg, unmapped, wr;
  logic [31:0] a32;
  assign a32      = {16'h0, req_addr};
  assign in_reg   = a32 >= 32'(PERIPH_BASE);
  assign in_ram   = a32 < 32'(RAM_WORDS);
  assign in_rom   = (a32 >= 32'(ROM_BASE)) && (a32 < 32'(ROM_BASE + ROM_WORDS));
  assign unmapped = !in_reg && !in_ram && !in_rom;
  assign wr       = req_valid && req_we;

  assert_read_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |=> rd_valid);
  assert_no_stray_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid && !req_we));
  assert_unmapped_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(unmapped)) |-> (rd_data == 16'hFFFF));
  assert_illegal_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_pulse |-> $past(wr));
  assert_bad_write_flagged_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (in_rom || unmapped)) |=> illegal_pulse);
  assert_ram_we_scope_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (wr && in_ram));
  assert_rom_read_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |-> (req_valid && !req_we && in_rom));
  assert_start_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |-> $past(wr && (a32 == 32'(PERIPH_BASE + 4))));
  assert_start_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |-> (dma_len == ($past(req_wdata) & 16'hFFFC)));
  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq_pulse |-> $past(wr && (a32 == 32'(PERIPH_BASE + 'h0C)) && req_wdata[0]));
  assert_inbox_write_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ((a32 == 32'(PERIPH_BASE + 8)) || (a32 == 32'(PERIPH_BASE + 9)))) |=> illegal_pulse);
endmodule

bind dsp_dmem_decoder dsp_dmem_decoder_chk #(
  .RAM_WORDS(RAM_WORDS), .ROM_BASE(ROM_BASE), .ROM_WORDS(ROM_WORDS),
  .PERIPH_BASE(PERIPH_BASE), .XMEM_HI_W(XMEM_HI_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
  .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
  .rd_data(rd_data), .ram_we(ram_we), .rom_en(rom_en),
  .cpu_irq_pulse(cpu_irq_pulse), .dma_start(dma_start), .dma_len(dma_len),
  .illegal_pulse(illegal_pulse)
);

// File: tb/dsp_dmem_decoder_tb_top.sv
`timescale 1ns/1ps
module dsp_dmem_decoder_tb_top;
  localparam int RAM_WORDS = 1024;
  localparam int ROM_BASE  = 'h0800;
  localparam int ROM_WORDS = 1024;
  localparam int PB        = 'hFF00;
  localparam int NC        = 16;

  logic clk, rst_n;
  logic req_valid, req_we;
  logic [15:0] req_addr, req_wdata;
  logic rd_valid; logic [15:0] rd_data;
  logic ram_en, ram_we; logic [9:0] ram_addr; logic [15:0] ram_wdata, ram_rdata;
  logic rom_en; logic [9:0] rom_addr; logic [15:0] rom_rdata;
  logic [15:0] cpu_mbox_hi, cpu_mbox_lo; logic cpu_irq_pending;
  logic [15:0] dsp_mbox_hi, dsp_mbox_lo;
  logic cpu_irq_pulse, dma_start, illegal_pulse;
  logic [25:0] dma_xmem_addr; logic [15:0] dma_loc_addr, dma_len; logic [1:0] dma_ctrl;
  logic [31:0] acc_begin, acc_end, acc_cur;
  logic [15:0] acc_fmt, acc_pred, acc_hist1, acc_hist2, acc_gain;
  logic [NC*16-1:0] coef_flat;

  dsp_dmem_decoder dut_i (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // external memory models, one-cycle synchronous read
  logic [15:0] ram_mem [RAM_WORDS];
  logic [15:0] rom_mem [ROM_WORDS];
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) ram_mem[ram_addr] <= ram_wdata;
      ram_rdata <= ram_mem[ram_addr];
    end
    if (rom_en) rom_rdata <= rom_mem[rom_addr];
  end

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state, bus byte order
  logic [15:0] m_ram [RAM_WORDS];
  logic [15:0] m_xhi, m_xlo, m_loc, m_ctl, m_len, m_ohi, m_olo;
  logic [15:0] m_acc [11];
  logic [15:0] m_coef [NC];

  function automatic logic [15:0] swp(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction
  function automatic logic [15:0] rom_word(input int i);
    return 16'(i * 'h1357) ^ 16'hC0DE;
  endfunction
  function automatic int cat(input logic [15:0] a);
    if (a >= 16'(PB)) return 2;
    if (a < 16'(RAM_WORDS)) return 0;
    if (a >= 16'(ROM_BASE) && a < 16'(ROM_BASE + ROM_WORDS)) return 1;
    return 3;
  endfunction
  function automatic logic [15:0] reg_exp(input logic [7:0] o);
    case (o)
      8'h00: return m_xhi;  8'h01: return m_xlo;  8'h02: return m_loc;
      8'h03: return m_ctl;  8'h04: return m_len;
      8'h08: return cpu_mbox_hi;  8'h09: return cpu_mbox_lo;
      8'h0A: return m_ohi;  8'h0B: return m_olo;
      8'h0C: return {15'h0, cpu_irq_pending};
      default: return (o >= 8'h10 && o <= 8'h1A) ? m_acc[o - 8'h10] : 16'h0;
    endcase
  endfunction
  function automatic logic [NC*16-1:0] coef_exp();
    logic [NC*16-1:0] v;
    for (int k = 0; k < NC; k++) v[k*16 +: 16] = m_coef[k];
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_xhi = 0; m_xlo = 0; m_loc = 0; m_ctl = 0; m_len = 0; m_ohi = 0; m_olo = 0;
    for (int i = 0; i < 11; i++) m_acc[i] = 0;
    for (int k = 0; k < NC; k++) m_coef[k] = 0;
  endtask

  task automatic check_state(input string tag);
    chk({dsp_mbox_hi, dsp_mbox_lo} == {m_ohi, m_olo}, {"R8 mailbox out ", tag}, {dsp_mbox_hi, dsp_mbox_lo}, {m_ohi, m_olo});
    chk(dma_xmem_addr == {m_xhi[9:0], m_xlo}, {"R5 host address ", tag}, dma_xmem_addr, {m_xhi[9:0], m_xlo});
    chk({dma_loc_addr, 14'h0, dma_ctrl, dma_len} == {m_loc, m_ctl, m_len}, {"R6 local/ctrl/len ", tag},
        {dma_loc_addr, dma_ctrl, dma_len}, {m_loc, m_ctl[1:0], m_len});
    chk({acc_begin, acc_end, acc_cur, acc_fmt, acc_pred, acc_hist1, acc_hist2, acc_gain} ==
        {m_acc[0], m_acc[1], m_acc[2], m_acc[3], m_acc[4], m_acc[5], m_acc[6], m_acc[7], m_acc[8], m_acc[9], m_acc[10]},
        {"R10 accelerator regs ", tag}, {acc_begin, acc_end, acc_cur}, {m_acc[0], m_acc[1], m_acc[2], m_acc[3], m_acc[4], m_acc[5]});
    chk(coef_flat == coef_exp(), {"R10 coefficients ", tag}, coef_flat, coef_exp());
  endtask

  task automatic access(input bit we, input logic [15:0] a, input logic [15:0] w);
    int c = cat(a);
    logic [7:0] o = a[7:0];
    logic [15:0] exp_rd;
    bit exp_ill, exp_start, exp_irq;
    @(negedge clk);
    cpu_mbox_hi = 16'($urandom); cpu_mbox_lo = 16'($urandom); cpu_irq_pending = 1'($urandom);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = w;
    exp_rd = 16'hFFFF; exp_ill = 0; exp_start = 0; exp_irq = 0;
    if (!we) begin
      if (c == 0) exp_rd = m_ram[a];
      else if (c == 1) exp_rd = swp(rom_word(int'(a) - ROM_BASE));
      else if (c == 2) exp_rd = reg_exp(o);
    end else begin
      if (c == 0) m_ram[a] = w;
      else if (c == 1 || c == 3) exp_ill = 1;
      else case (o)
        8'h00: m_xhi = w & 16'h03FF;
        8'h01: m_xlo = w & 16'hFFFC;
        8'h02: m_loc = w & 16'hFFFE;
        8'h03: m_ctl = w & 16'h0003;
        8'h04: begin m_len = w & 16'hFFFC; exp_start = 1; end
        8'h08, 8'h09: exp_ill = 1;
        8'h0A: m_ohi = w;
        8'h0B: m_olo = w;
        8'h0C: exp_irq = w[0];
        default: begin
          if (o >= 8'h10 && o <= 8'h1A) m_acc[o - 8'h10] = w;
          else if (o >= 8'h20 && o < 8'h20 + NC) m_coef[o - 8'h20] = w;
        end
      endcase
    end
    #1;
    chk(ram_we == (we && c == 0), "R1 ram_we strobe", ram_we, (we && c == 0));
    chk(rom_en == (!we && c == 1), "R1 rom_en strobe", rom_en, (!we && c == 1));
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    chk(rd_valid == !we, "R12 rd_valid timing", rd_valid, !we);
    if (!we) chk(rd_data == exp_rd, c == 3 ? "R2 unmapped read" : "R1 read data", rd_data, exp_rd);
    chk(illegal_pulse == exp_ill, "R3 illegal flag", illegal_pulse, exp_ill);
    chk(dma_start == exp_start, "R7 dma_start", dma_start, exp_start);
    chk(cpu_irq_pulse == exp_irq, "R9 irq pulse", cpu_irq_pulse, exp_irq);
    check_state("after access");
    @(negedge clk);
    chk({rd_valid, dma_start, cpu_irq_pulse, illegal_pulse} == 4'b0, "R12 single-cycle pulses",
        {rd_valid, dma_start, cpu_irq_pulse, illegal_pulse}, 4'b0);
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < ROM_WORDS; i++) rom_mem[i] = rom_word(i);
    rst_n = 0; req_valid = 0; req_we = 0; req_addr = 0; req_wdata = 0;
    cpu_mbox_hi = 0; cpu_mbox_lo = 0; cpu_irq_pending = 0;
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk({rd_valid, dma_start, cpu_irq_pulse, illegal_pulse} == 4'b0, "R11 pulses after reset",
        {rd_valid, dma_start, cpu_irq_pulse, illegal_pulse}, 4'b0);
    check_state("R11 reset");

    // R4 byte order on the RAM port, plus prefill of RAM read locations
    access(1, 16'h0005, 16'h1234);
    chk(ram_mem[5] == 16'h3412, "R4 stored byte order", ram_mem[5], 16'h3412);
    for (int i = 0; i < 16; i++) access(1, 16'(i), 16'($urandom));
    for (int i = RAM_WORDS - 16; i < RAM_WORDS; i++) access(1, 16'(i), 16'($urandom));
    access(0, 16'h03FF, 0);                       // R1 RAM top
    access(0, 16'h0800, 0);                       // R1 ROM first word, R4 swap
    access(0, 16'h0BFF, 0);                       // R1 ROM last word
    access(0, 16'h0400, 0);                       // R2 hole below ROM
    access(0, 16'h07FF, 0);                       // R2
    access(0, 16'h0C00, 0);                       // R2 just above ROM
    access(0, 16'hFEFF, 0);                       // R2 just below registers
    access(1, 16'h0801, 16'hBEEF);                // R3 ROM write refused
    access(0, 16'h0801, 0);
    access(1, 16'h0500, 16'h1111);                // R3 unmapped write
    access(1, 16'hFF00, 16'hFFFF); access(0, 16'hFF00, 0);   // R5 high mask
    access(1, 16'hFF01, 16'hFFFF); access(0, 16'hFF01, 0);   // R5 low mask
    access(1, 16'hFF02, 16'hFFFF); access(0, 16'hFF02, 0);   // R6
    access(1, 16'hFF03, 16'hFFFF); access(0, 16'hFF03, 0);   // R6
    access(1, 16'hFF04, 16'h0123); access(0, 16'hFF04, 0);   // R7 launch
    access(1, 16'hFF08, 16'hAAAA); access(0, 16'hFF08, 0);   // R8 inbox write illegal
    access(1, 16'hFF0B, 16'h5A5A); access(0, 16'hFF0B, 0);   // R8 outbox
    access(1, 16'hFF0C, 16'h0001); access(1, 16'hFF0C, 16'hFFFE); // R9
    access(0, 16'hFF0C, 0);
    for (int k = 0; k < NC; k++) access(1, 16'(PB + 'h20 + k), 16'($urandom)); // R10
    access(0, 16'hFF25, 0);                       // R10 coefficient reads 0
    access(1, 16'hFF30, 16'h7777); access(1, 16'hFF31, 16'h8888); // R10 placeholders
    access(0, 16'hFF30, 0); access(0, 16'hFFC3, 0);

    for (int n = 0; n < 700; n++) begin
      int sel = int'($urandom % 6);
      bit we = 1'($urandom);
      logic [15:0] a;
      case (sel)
        0: begin
             int r = int'($urandom % 32);
             a = 16'(r < 16 ? r : RAM_WORDS - 32 + r);
           end
        1: a = 16'(ROM_BASE + int'($urandom % ROM_WORDS));
        2: a = ($urandom % 2) ? 16'(16'h0400 + $urandom % 16'h0400)
                              : 16'(16'h0C00 + $urandom % (PB - 'h0C00));
        3, 4: a = 16'(PB + int'($urandom % 64));
        default: a = 16'(PB + int'($urandom % 256));
      endcase
      access(we, a, 16'($urandom));
    end

    // R11 reset in the middle of operation
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    model_reset();
    repeat (4) @(negedge clk);
    check_state("R11 mid-run reset");
    access(0, 16'hFF0A, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule